// File: doc/BRIEF.md
# EPP Cycle Gate with Timeout

This block sits on the byte-oriented register bus of a basic printer port and adds the enhanced-parallel-port address and data registers. A host access to the address register (offset 3) or the data register (offset 4) becomes a handshaked byte cycle on the peripheral wires. Each cycle asserts a strobe, waits for the peripheral's wait/acknowledge input, then drops the strobe for one release cycle. The block also holds the port's control and output-data registers and merges a sticky timeout flag into the status byte it returns.

A cycle starts only when the direction and signal bits of the control byte match one exact pattern. Writes need the init bit alone. Reads need direction plus init. Any other setting drops the access at once. When the peripheral fails to answer within a programmable number of clocks, the timeout flag is set and the access ends early. Data-register accesses of 16 or 32 bits run as two or four byte cycles, least significant byte first. The host is held off with `ready_o` until the whole access has finished. A separate extended window at address bit 10 ignores writes and returns 0xFF.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the control byte reads 0xCC, the output-data byte reads 0xFF, the timeout flag is 0 and no strobe is active. Any access that does not run a byte cycle completes with `ready_o` high in the same cycle as `req_i`.
- R2: An accepted write or read at offset 3 runs its byte cycle on `addr_stb_o`. At offset 4 it runs on `data_stb_o`. A written byte appears on `pd_o` while the strobe is high.
- R3: A write to offset 3 or 4 runs only if (control & 0x2F) == 0x04. Otherwise it is dropped with no strobe.
- R4: A read of offset 3 or 4 runs only if (control & 0x2F) == 0x24. Otherwise it returns 0xFFFFFFFF with no strobe.
- R5: A byte cycle fails when `wait_i` stays low for L consecutive strobe clocks, where L is `tmo_limit_i` and 0 counts as 1. A failure sets the timeout flag and abandons the remaining bytes. Bytes a read never received return as 0xFF.
- R6: A status read (offset 1) returns {`status_i[7:1]`, timeout flag}. A status write with bit 0 = 1 clears the flag, and with bit 0 = 0 leaves it unchanged.
- R7: At offset 4, `size_i` = 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. The bytes are taken from or placed into `wdata_i`/`rdata_o` least significant first. Offset 3 always moves a single byte.
- R8: A control write (offset 2) stores bits 5:0. Bits 7:6 always read as 1. `dir_o` follows bit 5 and `ctrl_lines_o` follows bits 3:0.
- R9: With `addr_i[10]` set, writes have no effect and reads return 0x000000FF.
- R10: `ready_o` stays low while a byte cycle is in progress. It rises once, in the cycle after the last byte's release clock or after the failing strobe clock. An access therefore takes 1 + Σ(dᵢ+2) observation cycles, where dᵢ is each byte's acknowledge delay, plus L for a failing byte.
- R11: A write to offset 0 stores the output-data byte, which drives `pd_o` outside write cycles. A read of offset 0 returns `pd_i` when `dir_o` is 1 and the stored byte otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Register address; bits 2:0 offset, bit 10 extended window |
| size_i | input | 2 | Data-register access width: 0 byte, 1 half, 2/3 word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while ready_o is high |
| ready_o | output | 1 | Access complete |
| tmo_limit_i | input | 16 | Acknowledge timeout in clocks |
| status_i | input | 7 | Peripheral status lines, bits 7:1 |
| dir_o | output | 1 | Data-line direction, 1 = input from peripheral |
| ctrl_lines_o | output | 4 | Control signal lines |
| pd_o | output | 8 | Data lines toward the peripheral |
| pd_i | input | 8 | Data lines from the peripheral |
| addr_stb_o | output | 1 | Address cycle strobe |
| data_stb_o | output | 1 | Data cycle strobe |
| write_o | output | 1 | Current cycle is a write |
| wait_i | input | 1 | Peripheral wait/acknowledge |

## Verification
A wrong gate decision shows at once. A strobe appears where none is allowed, or an access that should stall returns in the same cycle, and both are caught on the first affected access. A corrupt byte index or timeout counter shows up in the observation-cycle count and in the byte order of the logged peripheral traffic by the end of that access. A stuck timeout flag shows on the next status read. A wrong control register shows on `dir_o` and `ctrl_lines_o` by the following clock.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam logic [5:0] CTRL_RST  = 6'h0C;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_STROBE,
    CYC_RELEASE,
    CYC_DONE
  } cyc_state_e;

  typedef struct packed {
    logic       wr;
    logic       is_addr;
    logic [2:0] nbytes;
  } cyc_req_t;
endpackage

// File: rtl/epp_port_regs.sv
module epp_port_regs
  import epp_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] off_i,
  input  logic [7:0] wdata_i,
  input  logic       fail_i,
  input  logic [7:1] status_i,
  input  logic [7:0] pd_i,
  output logic [5:0] ctrl_o,
  output logic [7:0] dataw_o,
  output logic       flag_o,
  output logic [7:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= CTRL_RST;
      dataw_o <= 8'hFF;
      flag_o  <= 1'b0;
    end else begin
      if (fail_i) flag_o <= 1'b1;
      if (wr_i) begin
        case (off_i)
          OFF_DATA: dataw_o <= wdata_i;
          OFF_CTRL: ctrl_o  <= wdata_i[5:0];
          OFF_STAT: if (wdata_i[0]) flag_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off_i)
      OFF_DATA: rdata_o = ctrl_o[5] ? pd_i : dataw_o;
      OFF_STAT: rdata_o = {status_i, flag_o};
      OFF_CTRL: rdata_o = {2'b11, ctrl_o};
      default:  rdata_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/epp_gate_decode.sv
module epp_gate_decode
  import epp_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [5:0]        ctrl_i,
  output logic              map_o,
  output logic              epp_o,
  output logic              ok_o,
  output cyc_req_t          cyc_o
);
  localparam int unsigned MID_W = ADDR_W - 4;

  logic [2:0]       off;
  logic [MID_W-1:0] mid;
  logic [7:0]       masked;

  assign off    = addr_i[2:0];
  assign mid    = addr_i[ADDR_W-2:3];
  assign map_o  = !addr_i[ADDR_W-1] && (mid == '0);
  assign epp_o  = map_o && (off == OFF_EADDR || off == OFF_EDATA);
  assign masked = {2'b00, ctrl_i} & GATE_MASK;
  assign ok_o   = we_i ? (masked == GATE_WR) : (masked == GATE_RD);

  always_comb begin
    cyc_o.wr      = we_i;
    cyc_o.is_addr = (off == OFF_EADDR);
    if (off == OFF_EADDR)   cyc_o.nbytes = 3'd1;
    else if (size_i == 2'd0) cyc_o.nbytes = 3'd1;
    else if (size_i == 2'd1) cyc_o.nbytes = 3'd2;
    else                     cyc_o.nbytes = 3'd4;
  end
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_gate_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cyc_req_t         req_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             wait_i,
  input  logic [7:0]       pd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [BUS_W-1:0] rbuf_o,
  output logic             addr_stb_o,
  output logic             data_stb_o,
  output logic             write_o,
  output logic [7:0]       pd_o
);
  localparam int unsigned NBYTES = BUS_W / 8;
  localparam int unsigned IDX_W  = $clog2(NBYTES);

  cyc_state_e       state;
  cyc_req_t         cur;
  logic [BUS_W-1:0] wbuf;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_eff;
  logic             hit_lim;
  logic             last;

  assign lim_eff = (limit_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit_i;
  assign hit_lim = ({1'b0, cnt} + 1'b1) >= {1'b0, lim_eff};
  assign last    = ((IDX_W+1)'(idx) + 1'b1) == (IDX_W+1)'(cur.nbytes);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= CYC_IDLE;
      cur    <= '0;
      wbuf   <= '0;
      rbuf_o <= '1;
      idx    <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        CYC_IDLE: if (start_i) begin
          cur    <= req_i;
          wbuf   <= wdata_i;
          rbuf_o <= '1;
          idx    <= '0;
          cnt    <= '0;
          state  <= CYC_STROBE;
        end
        CYC_STROBE: begin
          if (wait_i) begin
            if (!cur.wr) rbuf_o[{idx, 3'b000} +: 8] <= pd_i;
            state <= CYC_RELEASE;
          end else if (hit_lim) begin
            state <= CYC_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CYC_RELEASE: begin
          cnt <= '0;
          if (last) state <= CYC_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= CYC_STROBE;
          end
        end
        default: state <= CYC_IDLE;
      endcase
    end
  end

  assign busy_o     = (state != CYC_IDLE);
  assign done_o     = (state == CYC_DONE);
  assign fail_o     = (state == CYC_STROBE) && !wait_i && hit_lim;
  assign addr_stb_o = (state == CYC_STROBE) && cur.is_addr;
  assign data_stb_o = (state == CYC_STROBE) && !cur.is_addr;
  assign write_o    = (state == CYC_STROBE || state == CYC_RELEASE) && cur.wr;
  assign pd_o       = wbuf[{idx, 3'b000} +: 8];
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ready_o,
  input  logic [CNT_W-1:0]  tmo_limit_i,
  input  logic [7:1]        status_i,
  output logic              dir_o,
  output logic [3:0]        ctrl_lines_o,
  output logic [7:0]        pd_o,
  input  logic [7:0]        pd_i,
  output logic              addr_stb_o,
  output logic              data_stb_o,
  output logic              write_o,
  input  logic              wait_i
);
  logic [5:0]       ctrl;
  logic [7:0]       dataw;
  logic             flag;
  logic [7:0]       reg_rd;
  logic             map, epp, ok;
  cyc_req_t         cyc;
  logic             busy, done, fail, start, reg_wr;
  logic [BUS_W-1:0] rbuf;
  logic [7:0]       seq_pd;

  epp_gate_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .we_i   (we_i),
    .ctrl_i (ctrl),
    .map_o  (map),
    .epp_o  (epp),
    .ok_o   (ok),
    .cyc_o  (cyc)
  );

  assign start  = !busy && req_i && epp && ok;
  assign reg_wr = !busy && req_i && we_i && map && !epp;

  epp_port_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr),
    .off_i    (addr_i[2:0]),
    .wdata_i  (wdata_i[7:0]),
    .fail_i   (fail),
    .status_i (status_i),
    .pd_i     (pd_i),
    .ctrl_o   (ctrl),
    .dataw_o  (dataw),
    .flag_o   (flag),
    .rdata_o  (reg_rd)
  );

  epp_byte_seq #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_i      (cyc),
    .wdata_i    (wdata_i),
    .limit_i    (tmo_limit_i),
    .wait_i     (wait_i),
    .pd_i       (pd_i),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail),
    .rbuf_o     (rbuf),
    .addr_stb_o (addr_stb_o),
    .data_stb_o (data_stb_o),
    .write_o    (write_o),
    .pd_o       (seq_pd)
  );

  assign ready_o = done || (!busy && req_i && !start);

  always_comb begin
    if (done)     rdata_o = rbuf;
    else if (epp) rdata_o = '1;
    else if (map) rdata_o = {{(BUS_W-8){1'b0}}, reg_rd};
    else          rdata_o = {{(BUS_W-8){1'b0}}, 8'hFF};
  end

  assign dir_o        = ctrl[5];
  assign ctrl_lines_o = ctrl[3:0];
  assign pd_o         = write_o ? seq_pd : dataw;

  // flag is internal; only its effect on status reads is observable
  logic unused_flag;
  assign unused_flag = flag;
endmodule

// File: rtl/epp_cycle_gate_chk.sv
module epp_cycle_gate_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              ready_o,
  input logic              dir_o,
  input logic [3:0]        ctrl_lines_o,
  input logic [7:0]        pd_o,
  input logic              addr_stb_o,
  input logic              data_stb_o,
  input logic              write_o
);
  logic stb;
  assign stb = addr_stb_o || data_stb_o;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_stb_o && data_stb_o)) else $error("two strobes");  // R2
  AST_WR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && write_o) |-> (!dir_o && ctrl_lines_o == 4'h4)) else $error("write gate");  // R3
  AST_RD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !write_o) |-> (dir_o && ctrl_lines_o == 4'h4)) else $error("read gate");  // R4
  AST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |-> !ready_o) else $error("ready during strobe");  // R10
  AST_WR_BYTE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && write_o && $past(stb && write_o)) |-> $stable(pd_o)) else $error("byte moved");  // R2
  AST_EXT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1] && !stb && !write_o) |-> (ready_o && rdata_o == BUS_W'(8'hFF)))
    else $error("extended window");  // R9
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_epp_cycle_gate.sv
`timescale 1ns/1ps
module tb_epp_cycle_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [10:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic [15:0] tmo_limit = 16'd8;
  logic [7:0]  status_in = 8'hA5;
  logic        dir, addr_stb, data_stb, wr_cyc;
  logic [3:0]  ctrl_lines;
  logic [7:0]  pd_out;
  logic [7:0]  pd_in = 8'h00;
  logic        wait_in = 1'b0;

  int total = 0, fails = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  epp_cycle_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .tmo_limit_i(tmo_limit), .status_i(status_in[7:1]), .dir_o(dir),
    .ctrl_lines_o(ctrl_lines), .pd_o(pd_out), .pd_i(pd_in),
    .addr_stb_o(addr_stb), .data_stb_o(data_stb), .write_o(wr_cyc), .wait_i(wait_in)
  );

  // reference state
  logic [5:0] m_ctrl  = 6'h0C;
  logic [7:0] m_dataw = 8'hFF;
  bit         m_flag  = 0;

  // peripheral model
  int         dly_q[$];
  logic [7:0] rd_q[$];
  logic [8:0] log_q[$];
  int seen = 0, cur_d = 0;

  always @(negedge clk) begin
    if (addr_stb || data_stb) begin
      seen++;
      if (seen == 1) cur_d = (dly_q.size() > 0) ? dly_q.pop_front() : 0;
      if (cur_d >= 0 && seen == cur_d + 1) begin
        wait_in = 1'b1;
        if (wr_cyc) log_q.push_back({addr_stb, pd_out});
        else pd_in = (rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
      end
    end else begin
      seen = 0;
      wait_in = 1'b0;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of control-driven outputs
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk(dir === m_ctrl[5] && ctrl_lines === m_ctrl[3:0], "R8 control lines",
          {27'h0, dir, ctrl_lines}, {27'h0, m_ctrl[5], m_ctrl[3:0]});
    end
  end

  task automatic run(bit w, logic [10:0] a, logic [1:0] sz, logic [31:0] wd, string tag);
    logic [31:0] exp_rd;
    logic [8:0]  exp_log[$];
    int          dq[$];
    logic [7:0]  rq[$];
    int          exp_n, n, nb, lim;
    bit          ok;
    logic [2:0]  off;
    logic [7:0]  masked;
    off = a[2:0];
    exp_rd = 32'h0000_00FF;
    exp_n = 0;
    lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
    if (!a[10] && a[9:3] == 0) begin
      case (off)
        3'd0: exp_rd = {24'h0, m_ctrl[5] ? pd_in : m_dataw};
        3'd1: exp_rd = {24'h0, status_in[7:1], m_flag};
        3'd2: exp_rd = {24'h0, 2'b11, m_ctrl};
        3'd3, 3'd4: begin
          exp_rd = 32'hFFFF_FFFF;
          masked = {2'b00, m_ctrl} & 8'h2F;
          ok = w ? (masked == 8'h04) : (masked == 8'h24);
          nb = (off == 3) ? 1 : (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
          if (ok) begin
            dq = dly_q;
            rq = rd_q;
            exp_n = 1;
            for (int i = 0; i < nb; i++) begin
              int d;
              d = (dq.size() > 0) ? dq.pop_front() : 0;
              if (d < 0 || d >= lim) begin
                exp_n += lim;
                m_flag = 1;
                break;
              end
              exp_n += d + 2;
              if (w) exp_log.push_back({off == 3, wd[i*8 +: 8]});
              else exp_rd[i*8 +: 8] = (rq.size() > 0) ? rq.pop_front() : 8'h00;
            end
          end
        end
        default: exp_rd = 32'h0000_00FF;
      endcase
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    #1;
    n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (!ready) chk(0, {tag, " R10 no ready"}, 0, 1);
    if (!w) chk(rdata === exp_rd, {tag, " rdata"}, rdata, exp_rd);
    chk(n == exp_n, {tag, " R10 cycles"}, n, exp_n);
    if (w && !a[10] && a[9:3] == 0) begin
      if (off == 3'd0) m_dataw = wd[7:0];
      if (off == 3'd2) m_ctrl = wd[5:0];
      if (off == 3'd1 && wd[0]) m_flag = 0;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    begin
      bit same;
      same = (log_q.size() == exp_log.size());
      if (same) foreach (exp_log[i]) if (log_q[i] !== exp_log[i]) same = 0;
      chk(same, {tag, " peripheral bytes"}, log_q.size(), exp_log.size());
    end
    log_q.delete();
    dly_q.delete();
    rd_q.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(!ready && !addr_stb && !data_stb && !wr_cyc, "R1 idle outputs", {ready, addr_stb, data_stb, wr_cyc}, 0);
    chk(pd_out === 8'hFF, "R1 R11 pd after reset", pd_out, 8'hFF);
    started = 1;
    run(0, 11'h002, 0, 0, "R1 R8 ctrl reset");
    run(0, 11'h000, 0, 0, "R1 R11 data reset");
    run(0, 11'h001, 0, 0, "R1 R6 status reset");
    // R11 data register
    run(1, 11'h000, 0, 32'h3C, "R11 data write");
    run(0, 11'h000, 0, 0, "R11 data read");
    chk(pd_out === 8'h3C, "R11 pd drives data", pd_out, 8'h3C);
    // R3 gated write with select set
    run(1, 11'h004, 0, 32'h55, "R3 gated write ctrl 0x0C");
    // enter write mode
    run(1, 11'h002, 0, 32'h04, "R8 ctrl write 0x04");
    dly_q = '{2};
    run(1, 11'h003, 0, 32'h5A, "R2 address write");
    dly_q = '{0, 1, 3, 0};
    run(1, 11'h004, 2, 32'h11223344, "R7 word write");
    dly_q = '{1, 0};
    run(1, 11'h004, 1, 32'h0000BEEF, "R7 half write");
    run(1, 11'h003, 2, 32'hA1B2C3D4, "R7 address one byte");
    run(0, 11'h004, 1, 0, "R4 gated read in write mode");
    // read mode
    run(1, 11'h002, 0, 32'h24, "R8 ctrl write 0x24");
    pd_in = 8'h96;
    run(0, 11'h000, 0, 0, "R11 data read follows pd_i");
    rd_q = '{8'h77};
    dly_q = '{1};
    run(0, 11'h003, 0, 0, "R2 R4 address read");
    rd_q = '{8'h01, 8'h02, 8'h03, 8'h04};
    dly_q = '{0, 2, 1, 0};
    run(0, 11'h004, 2, 0, "R7 word read");
    run(1, 11'h003, 0, 32'h99, "R3 gated write in read mode");
    // timeouts
    tmo_limit = 16'd6;
    run(1, 11'h002, 0, 32'h04, "R8 back to write mode");
    dly_q = '{-1};
    run(1, 11'h004, 2, 32'hCAFEF00D, "R5 write timeout");
    status_in = 8'hA4;
    run(0, 11'h001, 0, 0, "R6 status shows flag");
    run(1, 11'h001, 0, 32'h00, "R6 status write bit0=0");
    run(0, 11'h001, 0, 0, "R6 flag kept");
    run(1, 11'h001, 0, 32'h01, "R6 status write bit0=1");
    run(0, 11'h001, 0, 0, "R6 flag cleared");
    run(1, 11'h002, 0, 32'h24, "R8 read mode again");
    rd_q = '{8'h10, 8'h20, 8'h30};
    dly_q = '{0, 2, -1};
    run(0, 11'h004, 2, 0, "R5 partial read abandons");
    run(0, 11'h001, 0, 0, "R5 R6 flag after partial");
    run(1, 11'h001, 0, 32'h01, "R6 clear again");
    tmo_limit = 16'd3;
    rd_q = '{8'h42};
    dly_q = '{2};
    run(0, 11'h003, 0, 0, "R5 delay just inside limit");
    dly_q = '{3};
    run(0, 11'h003, 0, 0, "R5 delay at limit fails");
    tmo_limit = 16'd0;
    rd_q = '{8'h5E};
    dly_q = '{0};
    run(0, 11'h004, 0, 0, "R5 limit zero acts as one");
    dly_q = '{1};
    run(0, 11'h004, 0, 0, "R5 limit zero fails");
    run(0, 11'h001, 0, 0, "R6 flag set by limit zero");
    // R9 extended window
    run(1, 11'h402, 0, 32'h00, "R9 extended write ignored");
    run(0, 11'h002, 0, 0, "R9 ctrl unchanged");
    run(0, 11'h404, 0, 0, "R9 extended read");
    run(0, 11'h005, 0, 0, "R1 unused offset");
    started = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule